// File: doc/BRIEF.md
# Compare Timer Core

A 16-bit up-counting timer that counts either ticks of an already divided time base or edges on one of several external pulse pins. Software configures it through a small word-addressed register port. A compare event happens when the counter holds the programmed compare value and one more count arrives. The event sets a sticky status flag, produces a one-cycle trigger pulse, and can drive an interrupt line.

After a compare event the counter either returns to zero or keeps counting until it wraps around past all-ones. The live count is not readable directly. A write of any value to the count register captures the current count into a holding register, and reads of that address return the held value. The divider that produces the time base is a separate block. This core only stores its setting and presents it on an output.

Register map (word addresses): 0 control/status, 1 prescale setting, 2 compare value, 3 count snapshot. Control/status bits: 0 run, 1 mode (0 = time ticks, 1 = pulse pins), 2 free-running, 3 polarity (0 = rising edges counted, 1 = falling edges counted), 4 interrupt enable, 5 compare flag, 7:6 pin select.

Top module: `cmp_timer_core`

## Requirements
- R1: After reset every register reads 0, and `trig_o` and `irq_o` are low.
- R2: In time mode with run set, the counter advances by one on each clock in which `tick_i` is high, and holds otherwise. A compare value C gives one compare event every C+1 ticks.
- R3: In pulse mode, only the pin named by the pin-select field (bits 7:6) is counted. With polarity 0 each rising edge counts. With polarity 1 each falling edge counts. Edges on the other pins have no effect.
- R4: With free-running clear, the counter returns to 0 on the count that causes the compare event.
- R5: With free-running set, the counter continues past the compare value and wraps from all-ones to 0.
- R6: The compare flag (bit 5) is set by a compare event and stays set. Writing 1 to bit 5 clears it. Writing 0 to bit 5 leaves it unchanged.
- R7: `trig_o` is high for exactly one clock per compare event, in the same cycle in which the flag becomes set.
- R8: `irq_o` is high exactly when the flag and the interrupt-enable bit (bit 4) are both set.
- R9: While run is clear, the counter is held at 0, no counts are taken, and the flag is cleared.
- R10: A write to address 3 captures the live count. Reads of address 3 return that captured value until the next write to address 3.
- R11: The control fields, the prescale setting and the compare value read back as written. The prescale setting also drives `psc_cfg_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| tick_i | input | 1 | Divided time base, one-cycle high per tick |
| pins_i | input | 4 | External pulse inputs |
| psc_cfg_o | output | 4 | Prescale setting for the external divider |
| trig_o | output | 1 | One-cycle pulse on each compare event |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take `tick_i` and `pins_i` as synchronous to `clk`. They take a register write as lasting a single cycle with a stable address and data. A disable is assumed to be seen for at least one clock before its effects are judged. The stimulus changes all inputs only on the falling edge. It pulses `tick_i` for one clock, or holds it high continuously in the long wrap run. Polarity is changed only while run is clear, so that a change of the sensed level is never taken as a countable edge.

// File: rtl/tc_pkg.sv
package tc_pkg;
   // register word addresses
   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_PSC  = 2'd1;
   localparam logic [1:0] ADR_CMP  = 2'd2;
   localparam logic [1:0] ADR_CNT  = 2'd3;
   // control/status bit positions
   localparam int B_RUN  = 0;
   localparam int B_MODE = 1;
   localparam int B_FREE = 2;
   localparam int B_POL  = 3;
   localparam int B_IE   = 4;
   localparam int B_FLAG = 5;
   localparam int B_SEL  = 6;

   typedef enum logic {
      SRC_TIME  = 1'b0,
      SRC_PULSE = 1'b1
   } src_mode_e;
endpackage

// File: rtl/tc_event.sv
module tc_event #(
   parameter int NPINS    = 4,
   parameter int SEL_W    = 2,
   parameter bit PIN_SYNC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tc_pkg::src_mode_e mode,
   input  logic             pol,
   input  logic [SEL_W-1:0] sel,
   input  logic             tick_i,
   input  logic [NPINS-1:0] pins_i,
   output logic             evt
);
   logic [NPINS-1:0] pins_s;
   logic             lvl;
   logic             lvl_prev;

   generate
      if (PIN_SYNC) begin : g_sync
         logic [NPINS-1:0] stg1, stg2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg1 <= '0;
               stg2 <= '0;
            end else begin
               stg1 <= pins_i;
               stg2 <= stg1;
            end
         end
         assign pins_s = stg2;
      end else begin : g_direct
         assign pins_s = pins_i;
      end
   endgenerate

   assign lvl = pins_s[sel] ^ pol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= lvl;
   end

   always_comb begin
      if (mode == tc_pkg::SRC_PULSE) evt = lvl & ~lvl_prev;
      else                           evt = tick_i;
   end
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             free_run,
   input  logic             evt,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             hit,
   output logic             trig
);
   assign hit = run & evt & (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         trig <= 1'b0;
      end else begin
         trig <= hit;
         if (!run) begin
            cnt <= '0;
         end else if (evt) begin
            if (hit && !free_run) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tc_regs.sv
module tc_regs #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 4,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              hit,
   input  logic [CNT_W-1:0]  cnt_live,
   output logic              run,
   output tc_pkg::src_mode_e mode,
   output logic              free_run,
   output logic              pol,
   output logic              ie,
   output logic [SEL_W-1:0]  sel,
   output logic              flag,
   output logic [CNT_W-1:0]  cmp,
   output logic [PSC_W-1:0]  psc
);
   import tc_pkg::*;

   logic [CNT_W-1:0] snap;
   logic wr_ctrl, wr_psc, wr_cmp, wr_cnt;

   assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
   assign wr_psc  = reg_wr && (reg_addr == ADR_PSC);
   assign wr_cmp  = reg_wr && (reg_addr == ADR_CMP);
   assign wr_cnt  = reg_wr && (reg_addr == ADR_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         mode     <= SRC_TIME;
         free_run <= 1'b0;
         pol      <= 1'b0;
         ie       <= 1'b0;
         sel      <= '0;
      end else if (wr_ctrl) begin
         run      <= reg_wdata[B_RUN];
         mode     <= src_mode_e'(reg_wdata[B_MODE]);
         free_run <= reg_wdata[B_FREE];
         pol      <= reg_wdata[B_POL];
         ie       <= reg_wdata[B_IE];
         sel      <= reg_wdata[B_SEL +: SEL_W];
      end
   end

   // sticky flag: disable clears, compare sets, set beats a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag <= 1'b0;
      else if (!run)                       flag <= 1'b0;
      else if (hit)                        flag <= 1'b1;
      else if (wr_ctrl && reg_wdata[B_FLAG]) flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp  <= '0;
         psc  <= '0;
         snap <= '0;
      end else begin
         if (wr_cmp) cmp  <= reg_wdata[CNT_W-1:0];
         if (wr_psc) psc  <= reg_wdata[PSC_W-1:0];
         if (wr_cnt) snap <= cnt_live;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADR_CTRL: begin
            reg_rdata[B_RUN]            = run;
            reg_rdata[B_MODE]           = mode;
            reg_rdata[B_FREE]           = free_run;
            reg_rdata[B_POL]            = pol;
            reg_rdata[B_IE]             = ie;
            reg_rdata[B_FLAG]           = flag;
            reg_rdata[B_SEL +: SEL_W]   = sel;
         end
         ADR_PSC: reg_rdata[PSC_W-1:0] = psc;
         ADR_CMP: reg_rdata[CNT_W-1:0] = cmp;
         ADR_CNT: reg_rdata[CNT_W-1:0] = snap;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 16,
   parameter int PSC_W    = 4,
   parameter int NPINS    = 4,
   parameter bit PIN_SYNC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tick_i,
   input  logic [NPINS-1:0]  pins_i,
   output logic [PSC_W-1:0]  psc_cfg_o,
   output logic              trig_o,
   output logic              irq_o
);
   localparam int SEL_W = (NPINS > 1) ? $clog2(NPINS) : 1;

   generate
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must not exceed DATA_W");
      end
      if (PSC_W > DATA_W) begin : g_bad_psc
         $error("PSC_W must not exceed DATA_W");
      end
      if (tc_pkg::B_SEL + SEL_W > DATA_W) begin : g_bad_sel
         $error("control fields do not fit in DATA_W");
      end
      if ((1 << SEL_W) != NPINS) begin : g_bad_pins
         $error("NPINS must be a power of two, at least 2");
      end
   endgenerate

   logic              run_w, fr_w, pol_w, ie_w, flag_w, evt_w, hit_w;
   tc_pkg::src_mode_e mode_w;
   logic [SEL_W-1:0]  sel_w;
   logic [CNT_W-1:0]  cmp_w, cnt_w;

   tc_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .hit(hit_w), .cnt_live(cnt_w),
      .run(run_w), .mode(mode_w), .free_run(fr_w), .pol(pol_w),
      .ie(ie_w), .sel(sel_w), .flag(flag_w), .cmp(cmp_w), .psc(psc_cfg_o)
   );

   tc_event #(
      .NPINS(NPINS), .SEL_W(SEL_W), .PIN_SYNC(PIN_SYNC)
   ) u_event (
      .clk(clk), .rst_n(rst_n), .mode(mode_w), .pol(pol_w), .sel(sel_w),
      .tick_i(tick_i), .pins_i(pins_i), .evt(evt_w)
   );

   tc_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk(clk), .rst_n(rst_n), .run(run_w), .free_run(fr_w),
      .evt(evt_w), .cmp(cmp_w), .cnt(cnt_w), .hit(hit_w), .trig(trig_o)
   );

   assign irq_o = flag_w & ie_w;
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_q,
   input logic              fr_q,
   input logic              ie_q,
   input logic              flag_q,
   input logic              evt,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              trig_o,
   input logic              irq_o,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata
);
   logic clr_req;
   assign clr_req = reg_wr && (reg_addr == tc_pkg::ADR_CTRL) && reg_wdata[tc_pkg::B_FLAG];

   AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !evt) |=> $stable(cnt_q)) else $error("count moved without event"); // R2

   AST_WRAP_ON_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o && !$past(fr_q)) |-> (cnt_q == '0)) else $error("no return to zero"); // R4

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && run_q && !clr_req) |=> flag_q) else $error("flag dropped"); // R6

   AST_TRIG_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> flag_q) else $error("trigger without flag"); // R7

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ie_q) else $error("interrupt while disabled"); // R8

   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> (cnt_q == '0 && !flag_q)) else $error("stopped timer not idle"); // R9
endmodule

bind cmp_timer_core tc_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_q(run_w), .fr_q(fr_w), .ie_q(ie_w),
   .flag_q(flag_w), .evt(evt_w), .cnt_q(cnt_w), .trig_o(trig_o),
   .irq_o(irq_o), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/cmp_timer_core_bench.sv
module cmp_timer_core_bench;
   localparam logic [1:0] A_CTRL = 2'd0, A_PSC = 2'd1, A_CMP = 2'd2, A_CNT = 2'd3;
   localparam logic [15:0] RUN = 16'h01, MODE = 16'h02, FREE = 16'h04,
                           POL = 16'h08, IE = 16'h10, FLG = 16'h20;

   // {compare, ticks, expected count, expected compare events}; time mode, reset-on-compare
   localparam int NVEC = 8;
   localparam logic [63:0] VEC [NVEC] = '{
      {16'd5, 16'd3,  16'd3, 16'd0},
      {16'd5, 16'd6,  16'd0, 16'd1},
      {16'd5, 16'd8,  16'd2, 16'd1},
      {16'd0, 16'd4,  16'd0, 16'd4},
      {16'd2, 16'd7,  16'd1, 16'd2},
      {16'd9, 16'd9,  16'd9, 16'd0},
      {16'd1, 16'd5,  16'd1, 16'd2},
      {16'd3, 16'd12, 16'd0, 16'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        tick_i = 1'b0;
   logic [3:0]  pins_i = '0;
   logic [3:0]  psc_cfg_o;
   logic        trig_o, irq_o;

   int n_chk = 0, n_err = 0, trig_cnt = 0;
   logic [15:0] rv;

   always #2 clk = ~clk;

   cmp_timer_core u_cmp_timer_core (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_i(tick_i),
      .pins_i(pins_i), .psc_cfg_o(psc_cfg_o), .trig_o(trig_o), .irq_o(irq_o)
   );

   always @(negedge clk) if (trig_o) trig_cnt++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic snap(output logic [15:0] d);
      wr(A_CNT, 16'h0);
      rd(A_CNT, d);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
   endtask

   task automatic pulse(input int idx);
      @(negedge clk); pins_i[idx] = 1'b1;
      @(negedge clk); pins_i[idx] = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 180000);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], rv);
         chk("R1 reset readback", rv, 16'h0);
      end
      chk("R1 trig after reset", trig_o, 1'b0);
      chk("R1 irq after reset", irq_o, 1'b0);

      // R11 readback
      wr(A_CTRL, 16'h00DE);
      rd(A_CTRL, rv); chk("R11 control readback", rv, 16'h00DE);
      wr(A_PSC, 16'h000A);
      rd(A_PSC, rv); chk("R11 prescale readback", rv, 16'h000A);
      chk("R11 prescale output", psc_cfg_o, 4'hA);
      wr(A_CMP, 16'hBEEF);
      rd(A_CMP, rv); chk("R11 compare readback", rv, 16'hBEEF);

      // R2 R4 R7 vector walk
      for (int v = 0; v < NVEC; v++) begin
         wr(A_CTRL, 16'h0);
         wr(A_CMP, VEC[v][63:48]);
         wr(A_CTRL, RUN);
         trig_cnt = 0;
         tick(int'(VEC[v][47:32]));
         snap(rv);
         chk($sformatf("R2 R4 vec%0d count", v), rv, VEC[v][31:16]);
         chk($sformatf("R7 vec%0d trigger pulses", v), trig_cnt, {16'h0, VEC[v][15:0]});
         rd(A_CTRL, rv);
         chk($sformatf("R6 vec%0d flag", v), rv[5], (VEC[v][15:0] != 0));
      end

      // R3 pulse mode, pin 2, rising edges
      wr(A_CTRL, 16'h0);
      wr(A_CMP, 16'd100);
      wr(A_CTRL, RUN | MODE | 16'h0080);
      pulse(2); pulse(2); pulse(2);
      snap(rv); chk("R3 rising edges on selected pin", rv, 16'd3);
      pulse(0); pulse(1); pulse(3);
      snap(rv); chk("R3 other pins ignored", rv, 16'd3);
      // R3 falling edges with polarity 1 (set while stopped)
      wr(A_CTRL, MODE | POL | 16'h0080);
      wr(A_CTRL, RUN | MODE | POL | 16'h0080);
      @(negedge clk); pins_i[2] = 1'b1;
      @(negedge clk);
      snap(rv); chk("R3 rising edge ignored when inverted", rv, 16'd0);
      @(negedge clk); pins_i[2] = 1'b0;
      @(negedge clk);
      snap(rv); chk("R3 falling edge counted when inverted", rv, 16'd1);

      // R6 R8 R9 flag, interrupt and stop
      wr(A_CTRL, 16'h0);
      wr(A_CMP, 16'd1);
      wr(A_CTRL, RUN);
      tick(2);
      chk("R8 irq low without enable", irq_o, 1'b0);
      wr(A_CTRL, RUN);
      rd(A_CTRL, rv); chk("R6 writing 0 keeps flag", rv, 16'h0021);
      wr(A_CTRL, RUN | IE);
      rd(A_CTRL, rv); chk("R6 flag still set", rv, 16'h0031);
      chk("R8 irq with flag and enable", irq_o, 1'b1);
      wr(A_CTRL, RUN | IE | FLG);
      rd(A_CTRL, rv); chk("R6 write one clears flag", rv, 16'h0011);
      chk("R8 irq low after clear", irq_o, 1'b0);
      tick(3);
      chk("R8 irq after new compare", irq_o, 1'b1);
      wr(A_CTRL, 16'h0);
      rd(A_CTRL, rv); chk("R9 stop clears flag", rv, 16'h0000);
      chk("R9 irq low when stopped", irq_o, 1'b0);
      tick(2);
      wr(A_CTRL, RUN);
      snap(rv); chk("R9 counter zero and no counts while stopped", rv, 16'd0);

      // R10 snapshot holds
      wr(A_CTRL, 16'h0);
      wr(A_CMP, 16'd200);
      wr(A_CTRL, RUN);
      tick(3);
      wr(A_CNT, 16'hFFFF);
      tick(2);
      rd(A_CNT, rv); chk("R10 read returns held value", rv, 16'd3);
      snap(rv); chk("R10 new capture", rv, 16'd5);

      // R5 free running, short then full wrap
      wr(A_CTRL, 16'h0);
      wr(A_CMP, 16'd2);
      wr(A_CTRL, RUN | FREE);
      tick(5);
      snap(rv); chk("R5 counts past compare", rv, 16'd5);
      wr(A_CTRL, 16'h0);
      wr(A_CMP, 16'd3);
      wr(A_CTRL, RUN | FREE);
      trig_cnt = 0;
      @(negedge clk); tick_i = 1'b1;
      repeat (65538) @(negedge clk);
      tick_i = 1'b0;
      snap(rv); chk("R5 wraps through all-ones", rv, 16'd2);
      chk("R5 single compare event per wrap", trig_cnt, 1);
      rd(A_CTRL, rv); chk("R5 flag set in free run", rv, 16'h0025);

      finish_run();
   end
endmodule